// File: doc/BRIEF.md
# Double-Buffered Oscillator Tuning Register File

This block is the write-only control port of a numerically controlled oscillator. A host presents a byte on an 8-bit data bus and a 4-bit address, then pulses a write strobe while a write enable is held. Six bytes build each 48-bit frequency word, and one byte carries control bits. There is a center word, an offset word and the control byte. Every write lands in a master copy. The oscillator reads only a slave copy, so a new setting takes effect as one coherent step.

An update input copies the whole master set into the slave set in one clock cycle. The host has two ways to use it. It can load all bytes with update low and then raise update. Or it can hold update high while it writes, and each byte then reaches the oscillator as soon as it lands. In the second mode, partial frequency values show on the outputs. The strobe and update inputs are asynchronous to the oscillator clock. Each one passes through a two-flop synchronizer and edge detection, so every strobe pulse and every update assertion is acted on exactly once.

Top module: `nco_ctrl_regs`

## Requirements
- R1: A byte is captured only on a rising edge of `wr_strobe` that occurs while `wr_en` is 1. A strobe with `wr_en` at 0 changes no register.
- R2: Address n (0 to 5) writes bits [8n+7:8n] of the center word. Address 6+n (n from 0 to 5) writes bits [8n+7:8n] of the offset word.
- R3: Address 13 writes the control byte. Bit 5 of the control byte is the accumulator-feedback enable and appears on `acc_run`. Writes to addresses 12, 14 and 15 change nothing.
- R4: While `upd` is low, writes change only the master copy. `center_word`, `offset_word` and `ctrl_word` do not change.
- R5: A rising edge of `upd` copies all master registers to the outputs in the same cycle. The new values appear after the third rising clock edge that follows the change of `upd`, and not after the second.
- R6: While `upd` is held high, each written byte reaches the outputs on its own, after the fourth rising clock edge that follows the strobe rise, and not after the third. The unwritten bytes keep their earlier values.
- R7: After reset, both frequency words are 0 and the control byte is 0x20, so `acc_run` is 1.
- R8: A strobe held high for many cycles writes once. Data that changes while the strobe is still high is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, is released synchronously |
| wr_data | input | 8 | Write byte |
| wr_addr | input | 4 | Register address |
| wr_strobe | input | 1 | Asynchronous write strobe; acts on its rising edge |
| wr_en | input | 1 | Write enable, sampled when the strobe edge is seen |
| upd | input | 1 | Asynchronous master-to-slave transfer control |
| center_word | output | 48 | Slave center frequency word |
| offset_word | output | 48 | Slave offset frequency word |
| ctrl_word | output | 8 | Slave control byte |
| acc_run | output | 1 | Accumulator-feedback enable (control bit 5) |

## Verification
A strobe rise goes through two synchronizer flops and one edge register before the master is written. In update-held mode, one more register copies the master to the slave, so a byte reaches the outputs four rising edges after the strobe changes. An update rise takes two synchronizer flops plus the slave register, which is three edges. The bench drives inputs on falling edges and samples on falling edges. At each latency it samples one edge early and expects the old value, then one edge later and expects the new value. In load-then-update mode, it checks after every write that the outputs have not moved.

// File: rtl/nco_ctrl_pkg.sv
package nco_ctrl_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 4;
  localparam int FREQ_BYTES   = 6;
  localparam int FREQ_W       = FREQ_BYTES * DATA_W;
  localparam int CENTER_BASE  = 0;
  localparam int OFFSET_BASE  = CENTER_BASE + FREQ_BYTES;
  localparam int CTRL_ADDR    = 13;
  localparam int ACC_RUN_BIT  = 5;
  localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(1) << ACC_RUN_BIT;

  typedef logic [FREQ_W-1:0] freq_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nco_sync_level.sv
module nco_sync_level #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[STAGES-1];
endmodule

// File: rtl/nco_master_bank.sv
module nco_master_bank
  import nco_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  output freq_t             center_m,
  output freq_t             offset_m,
  output byte_t             ctrl_m
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  freq_t center_q, center_d, offset_q, offset_d;
  byte_t ctrl_q, ctrl_d;
  logic  hit;

  assign hit = wr_go & wr_en;

  for (genvar gi = 0; gi < FREQ_BYTES; gi++) begin : g_byte
    localparam logic [ADDR_W-1:0] C_A = ADDR_W'(CENTER_BASE + gi);
    localparam logic [ADDR_W-1:0] O_A = ADDR_W'(OFFSET_BASE + gi);
    assign center_d[gi*DATA_W +: DATA_W] =
      (hit && wr_addr == C_A) ? wr_data : center_q[gi*DATA_W +: DATA_W];
    assign offset_d[gi*DATA_W +: DATA_W] =
      (hit && wr_addr == O_A) ? wr_data : offset_q[gi*DATA_W +: DATA_W];
  end

  always_comb ctrl_d = (hit && wr_addr == CTRL_A) ? wr_data : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      center_q <= '0;
      offset_q <= '0;
      ctrl_q   <= CTRL_RESET;
    end else begin
      center_q <= center_d;
      offset_q <= offset_d;
      ctrl_q   <= ctrl_d;
    end
  end

  assign center_m = center_q;
  assign offset_m = offset_q;
  assign ctrl_m   = ctrl_q;
endmodule

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
  import nco_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_strobe,
  input  logic              wr_en,
  input  logic              upd,
  output logic [FREQ_W-1:0] center_word,
  output logic [FREQ_W-1:0] offset_word,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              acc_run
);
  logic  rst_sync_n;
  logic  wr_lvl, upd_lvl;
  logic  wr_prev_q, upd_prev_q, wr_go_q;
  logic  wr_go, upd_rise, xfer;
  freq_t center_m, offset_m, center_q, center_d, offset_q, offset_d;
  byte_t ctrl_m, ctrl_q, ctrl_d;

  nco_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  nco_sync_level #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(wr_strobe), .level(wr_lvl));

  nco_sync_level #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_in(upd), .level(upd_lvl));

  assign wr_go    = wr_lvl & ~wr_prev_q;
  assign upd_rise = upd_lvl & ~upd_prev_q;

  nco_master_bank u_master (
    .clk(clk), .rst_n(rst_sync_n), .wr_go(wr_go), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .center_m(center_m), .offset_m(offset_m), .ctrl_m(ctrl_m));

  // Transfer on the update edge, and while update is held, once after each write.
  always_comb begin
    xfer     = upd_lvl & (upd_rise | wr_go_q);
    center_d = xfer ? center_m : center_q;
    offset_d = xfer ? offset_m : offset_q;
    ctrl_d   = xfer ? ctrl_m   : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_prev_q  <= 1'b0;
      upd_prev_q <= 1'b0;
      wr_go_q    <= 1'b0;
      center_q   <= '0;
      offset_q   <= '0;
      ctrl_q     <= CTRL_RESET;
    end else begin
      wr_prev_q  <= wr_lvl;
      upd_prev_q <= upd_lvl;
      wr_go_q    <= wr_go;
      center_q   <= center_d;
      offset_q   <= offset_d;
      ctrl_q     <= ctrl_d;
    end
  end

  assign center_word = center_q;
  assign offset_word = offset_q;
  assign ctrl_word   = ctrl_q;
  assign acc_run     = ctrl_q[ACC_RUN_BIT];
endmodule

// File: rtl/nco_ctrl_regs_chk.sv
module nco_ctrl_regs_chk
  import nco_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_go,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              upd_lvl,
  input logic              upd_rise,
  input freq_t             center_m,
  input freq_t             offset_m,
  input byte_t             ctrl_m,
  input freq_t             center_word,
  input freq_t             offset_word,
  input byte_t             ctrl_word
);
  assert_disabled_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wr_en) |=> ($stable(center_m) && $stable(offset_m) && $stable(ctrl_m)));

  assert_unmapped_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_addr > 4'd11 && wr_addr != 4'd13)
      |=> ($stable(center_m) && $stable(offset_m) && $stable(ctrl_m)));

  assert_hold_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_lvl |=> ($stable(center_word) && $stable(offset_word) && $stable(ctrl_word)));

  assert_copy_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise |=> (center_word == $past(center_m) && offset_word == $past(offset_m)
                  && ctrl_word == $past(ctrl_m)));

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
endmodule

bind nco_ctrl_regs nco_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_go(wr_go), .wr_en(wr_en), .wr_addr(wr_addr),
  .upd_lvl(upd_lvl), .upd_rise(upd_rise),
  .center_m(center_m), .offset_m(offset_m), .ctrl_m(ctrl_m),
  .center_word(center_word), .offset_word(offset_word), .ctrl_word(ctrl_word));

// File: tb/nco_ctrl_regs_test.sv
module nco_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wr_data;
  logic [3:0]  wr_addr;
  logic        wr_strobe, wr_en, upd;
  logic [47:0] center_word, offset_word;
  logic [7:0]  ctrl_word;
  logic        acc_run;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [47:0] C1 = 48'h1234_5678_9ABC;
  localparam logic [47:0] O1 = 48'hFEDC_BA98_7654;
  localparam logic [47:0] C2 = 48'h0F1E_2D3C_4B5A;

  always #2.5 clk = ~clk;

  nco_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_addr(wr_addr),
    .wr_strobe(wr_strobe), .wr_en(wr_en), .upd(upd),
    .center_word(center_word), .offset_word(offset_word),
    .ctrl_word(ctrl_word), .acc_run(acc_run));

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [3:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = en; wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R7 center", center_word, 48'h0);
    check("R7 offset", offset_word, 48'h0);
    check("R7 ctrl", {40'h0, ctrl_word}, 48'h20);
    check("R7 acc_run", {47'h0, acc_run}, 48'h1);
  endtask

  task automatic t_load_then_update;
    for (int i = 0; i < 6; i++) begin
      write_byte(4'(i), C1[i*8 +: 8], 1'b1);
      check("R4 center frozen", center_word, 48'h0);
    end
    for (int i = 0; i < 6; i++) write_byte(4'(6 + i), O1[i*8 +: 8], 1'b1);
    write_byte(4'd13, 8'h7A, 1'b1);
    check("R4 offset frozen", offset_word, 48'h0);
    check("R4 ctrl frozen", {40'h0, ctrl_word}, 48'h20);
    @(negedge clk); upd = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 not yet", center_word, 48'h0);
    @(negedge clk);
    check("R5 R2 center", center_word, C1);
    check("R5 R2 offset", offset_word, O1);
    check("R5 R3 ctrl", {40'h0, ctrl_word}, 48'h7A);
    upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ignored;
    write_byte(4'd12, 8'hFF, 1'b1);
    write_byte(4'd14, 8'hFF, 1'b1);
    write_byte(4'd15, 8'hFF, 1'b1);
    write_byte(4'd3, 8'hEE, 1'b0);
    @(negedge clk); upd = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 R1 center kept", center_word, C1);
    check("R3 offset kept", offset_word, O1);
    check("R3 ctrl kept", {40'h0, ctrl_word}, 48'h7A);
    upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_partial;
    logic [47:0] exp;
    exp = C1;
    @(negedge clk); upd = 1'b1;
    repeat (4) @(negedge clk);
    // first byte with exact latency
    wr_addr = 4'd0; wr_data = C2[7:0]; wr_en = 1'b1; wr_strobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 not yet", center_word, C1);
    @(negedge clk);
    exp[7:0] = C2[7:0];
    check("R6 byte0", center_word, exp);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 1; i < 6; i++) begin
      write_byte(4'(i), C2[i*8 +: 8], 1'b1);
      exp[i*8 +: 8] = C2[i*8 +: 8];
      check("R6 partial", center_word, exp);
    end
    check("R6 offset untouched", offset_word, O1);
  endtask

  task automatic t_once;
    @(negedge clk);
    wr_addr = 4'd6; wr_data = 8'hAA; wr_en = 1'b1; wr_strobe = 1'b1;
    repeat (8) @(negedge clk);
    wr_data = 8'h55;
    repeat (6) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 single capture", offset_word, {O1[47:8], 8'hAA});
  endtask

  task automatic t_ctrl_bit;
    write_byte(4'd13, 8'h00, 1'b1);
    check("R3 acc_run low", {47'h0, acc_run}, 48'h0);
    write_byte(4'd13, 8'h20, 1'b1);
    check("R3 acc_run high", {47'h0, acc_run}, 48'h1);
    check("R3 ctrl value", {40'h0, ctrl_word}, 48'h20);
    upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_data = '0; wr_addr = '0; wr_strobe = 1'b0; wr_en = 1'b0; upd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_then_update();
    t_ignored();
    t_partial();
    t_once();
    t_ctrl_bit();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule